// File: doc/BRIEF.md
# Parallel Flash Page Programmer

This controller loads, reads back and checks the contents of a 32K x 8 parallel flash device. A host issues a request with an operation code, a 15-bit start address and a byte count. Write data and verify reference bytes arrive over a valid/ready byte stream. The controller drives the device's address, data and active-low chip-enable, output-enable and write-enable lines, and returns the bytes it reads as one-cycle result strobes.

Writes are grouped into 64-byte pages, in the order the bytes arrive. The whole image is never held. After the last byte of each page, and after the final byte of the request, the controller reads back the last written location. While the device is still programming, that location returns the inverse of the written byte. Polling ends when bit 7 of the read value equals bit 7 of the written byte, or fails after a set number of reads. Before every write strobe and every read sample, the data bus is given a programmable number of settling cycles. This allows for a slow bus isolated by series resistors.

In a programming session the host reads back the device, writes it, then verifies it. Verify returns each byte read next to the byte that was expected. It keeps a sticky mismatch flag and the address of the first byte that differed.

Top module: `flash_page_prog`

## Requirements
- R1: After reset, and whenever `req_ready` is high, the controller is idle. `fl_ce_n`, `fl_oe_n` and `fl_we_n` are 1, `fl_dq_oe` is 0, and `out_valid`, `done`, `err_timeout` and `mismatch` are 0.
- R2: `req_op` encodes 2'b00 read, 2'b01 write and 2'b10 verify. A request with `req_op` 2'b11, or with `req_len` 0, ends with a single `done` pulse and never asserts `fl_ce_n` low.
- R3: A read of N bytes from address A gives N `out_valid` pulses. Pulse k carries `out_addr` = A+k and `out_data` = the device content at that address.
- R4: Each write byte is taken from the stream exactly once and stored by one `fl_we_n` low pulse of one cycle at its address. Before the pulse, the address and data are held with `fl_dq_oe` high for at least `settle_cyc` cycles.
- R5: The write strobes between two polling phases all share address bits 14:6. A run of bytes inside one 64-byte page is polled once, after its last byte.
- R6: Polling reads the last written address and compares only bit 7 with bit 7 of the last written byte. The next page, or `done`, follows only after they match, that is, only after the device has finished programming.
- R7: Polling makes at most `poll_limit` reads, and at least one. If the last allowed read still differs, `err_timeout` is set and `done` pulses.
- R8: `fl_we_n` and `fl_oe_n` are never low together. `fl_dq_oe` is low while `fl_oe_n` is low and in the cycle before `fl_oe_n` falls.
- R9: A read value is sampled only after `fl_oe_n` has been low for `settle_cyc`+1 cycles.
- R10: In verify, each result carries the stream byte in `out_expect`. The first byte that differs sets the sticky `mismatch` flag and loads its address into `first_bad_addr`, which holds until the next request.
- R11: Accepting a new request clears `mismatch`, `first_bad_addr` and `err_timeout`.
- R12: `in_ready` is high only while the controller waits for a write or verify byte. Gaps in `in_valid` delay the operation but neither lose nor repeat bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle, request accepted |
| req_op | input | 2 | Operation code |
| req_addr | input | 15 | Start address |
| req_len | input | 16 | Byte count |
| settle_cyc | input | 8 | Bus settling cycles |
| poll_limit | input | 16 | Maximum polling reads per page |
| in_valid | input | 1 | Stream byte valid |
| in_ready | output | 1 | Stream byte taken |
| in_data | input | 8 | Write or reference byte |
| out_valid | output | 1 | Result strobe |
| out_addr | output | 15 | Address of result |
| out_data | output | 8 | Byte read from the device |
| out_expect | output | 8 | Reference byte (verify) |
| done | output | 1 | Request finished |
| err_timeout | output | 1 | Sticky polling timeout |
| mismatch | output | 1 | Sticky verify difference |
| first_bad_addr | output | 15 | First differing address |
| fl_addr | output | 15 | Device address |
| fl_dq_out | output | 8 | Data driven to the device |
| fl_dq_oe | output | 1 | Data drive enable |
| fl_dq_in | input | 8 | Data from the device |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_oe_n | output | 1 | Output enable, active low |
| fl_we_n | output | 1 | Write enable, active low |

## Verification
A wrong address counter shows on the next strobe as a result with the wrong `out_addr`, or as a byte landing outside its page. A bad page-end decision shows as the wrong number of polling phases within one request. A settle counter that ends early gives corrupted read data, or a strobe with too few stable cycles, on the very next access. A poll tracker that stops early raises `done` while the device model is still busy. A sticky flag that is lost or overwritten is visible at `mismatch` and `first_bad_addr` as soon as the request ends.

// File: rtl/fpp_pkg.sv
package fpp_pkg;

  typedef enum logic [1:0] {
    OP_READ   = 2'b00,
    OP_WRITE  = 2'b01,
    OP_VERIFY = 2'b10,
    OP_NONE   = 2'b11
  } op_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_WLOAD,
    S_WSETTLE,
    S_WSTROBE,
    S_PGAP,
    S_PREAD,
    S_RADDR,
    S_RREAD,
    S_DONE
  } st_e;

endpackage

// File: rtl/fpp_settle_timer.sv
module fpp_settle_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] limit,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = limit;
    else if (cnt_q != '0)
      cnt_d = cnt_q - {{(CNT_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/fpp_addr_seq.sv
module fpp_addr_seq #(
  parameter int ADDR_W = 15,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [LEN_W-1:0]  start_len,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic              rem_one,
  output logic              rem_zero
);

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [LEN_W-1:0]  rem_q, rem_d;

  always_comb begin
    addr_d = addr_q;
    rem_d  = rem_q;
    if (load) begin
      addr_d = start_addr;
      rem_d  = start_len;
    end else if (step) begin
      addr_d = addr_q + {{(ADDR_W-1){1'b0}}, 1'b1};
      rem_d  = rem_q - {{(LEN_W-1){1'b0}}, 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      rem_q  <= '0;
    end else begin
      addr_q <= addr_d;
      rem_q  <= rem_d;
    end
  end

  assign addr     = addr_q;
  assign rem_one  = (rem_q == {{(LEN_W-1){1'b0}}, 1'b1});
  assign rem_zero = (rem_q == '0);

endmodule

// File: rtl/fpp_poll_track.sv
module fpp_poll_track #(
  parameter int LIM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             sample,
  input  logic             want_bit,
  input  logic             got_bit,
  input  logic [LIM_W-1:0] limit,
  output logic             match,
  output logic             give_up
);

  logic [LIM_W-1:0] cnt_q, cnt_d;
  logic [LIM_W:0]   cnt_nx;

  assign match   = (want_bit == got_bit);
  assign cnt_nx  = {1'b0, cnt_q} + {{LIM_W{1'b0}}, 1'b1};
  assign give_up = !match && (cnt_nx >= {1'b0, limit});

  always_comb begin
    cnt_d = cnt_q;
    if (clear)
      cnt_d = '0;
    else if (sample && !match)
      cnt_d = cnt_nx[LIM_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/flash_page_prog.sv
module flash_page_prog
  import fpp_pkg::*;
#(
  parameter int ADDR_W   = 15,
  parameter int DATA_W   = 8,
  parameter int PAGE_W   = 6,
  parameter int SETTLE_W = 8,
  parameter int POLL_W   = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [1:0]          req_op,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [ADDR_W:0]     req_len,
  input  logic [SETTLE_W-1:0] settle_cyc,
  input  logic [POLL_W-1:0]   poll_limit,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [DATA_W-1:0]   in_data,
  output logic                out_valid,
  output logic [ADDR_W-1:0]   out_addr,
  output logic [DATA_W-1:0]   out_data,
  output logic [DATA_W-1:0]   out_expect,
  output logic                done,
  output logic                err_timeout,
  output logic                mismatch,
  output logic [ADDR_W-1:0]   first_bad_addr,
  output logic [ADDR_W-1:0]   fl_addr,
  output logic [DATA_W-1:0]   fl_dq_out,
  output logic                fl_dq_oe,
  input  logic [DATA_W-1:0]   fl_dq_in,
  output logic                fl_ce_n,
  output logic                fl_oe_n,
  output logic                fl_we_n
);

  localparam int LEN_W = ADDR_W + 1;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  st_e               state_q, state_d;
  op_e               op_q;
  logic [DATA_W-1:0] data_q, exp_q;
  logic [ADDR_W-1:0] last_addr_q;

  logic              tmr_load, tmr_done;
  logic              seq_load, seq_step, rem_one, rem_zero;
  logic [ADDR_W-1:0] seq_addr;
  logic              poll_clr, poll_smp, poll_match, poll_fail;
  logic              accept, page_end, is_verify;

  assign accept    = (state_q == S_IDLE) && req_valid;
  assign page_end  = (seq_addr[PAGE_W-1:0] == {PAGE_W{1'b1}});
  assign is_verify = (op_q == OP_VERIFY);

  fpp_settle_timer #(.CNT_W(SETTLE_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_i),
    .load    (tmr_load),
    .limit   (settle_cyc),
    .expired (tmr_done)
  );

  fpp_addr_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_i),
    .load       (seq_load),
    .start_addr (req_addr),
    .start_len  (req_len),
    .step       (seq_step),
    .addr       (seq_addr),
    .rem_one    (rem_one),
    .rem_zero   (rem_zero)
  );

  fpp_poll_track #(.LIM_W(POLL_W)) u_poll (
    .clk      (clk),
    .rst_n    (rst_i),
    .clear    (poll_clr),
    .sample   (poll_smp),
    .want_bit (data_q[DATA_W-1]),
    .got_bit  (fl_dq_in[DATA_W-1]),
    .limit    (poll_limit),
    .match    (poll_match),
    .give_up  (poll_fail)
  );

  // next state and sequencing strobes
  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    seq_load = 1'b0;
    seq_step = 1'b0;
    poll_clr = 1'b0;
    poll_smp = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (req_valid) begin
          seq_load = 1'b1;
          poll_clr = 1'b1;
          if (op_e'(req_op) == OP_NONE || req_len == '0)
            state_d = S_DONE;
          else if (op_e'(req_op) == OP_WRITE)
            state_d = S_WLOAD;
          else
            state_d = S_RADDR;
        end
      end
      S_WLOAD: begin
        if (in_valid) begin
          tmr_load = 1'b1;
          state_d  = S_WSETTLE;
        end
      end
      S_WSETTLE: begin
        if (tmr_done) state_d = S_WSTROBE;
      end
      S_WSTROBE: begin
        seq_step = 1'b1;
        state_d  = (rem_one || page_end) ? S_PGAP : S_WLOAD;
      end
      S_PGAP: begin
        tmr_load = 1'b1;
        state_d  = S_PREAD;
      end
      S_PREAD: begin
        if (tmr_done) begin
          poll_smp = 1'b1;
          if (poll_match) begin
            poll_clr = 1'b1;
            state_d  = rem_zero ? S_DONE : S_WLOAD;
          end else if (poll_fail) begin
            state_d = S_DONE;
          end else begin
            state_d = S_PGAP;
          end
        end
      end
      S_RADDR: begin
        if (!is_verify || in_valid) begin
          tmr_load = 1'b1;
          state_d  = S_RREAD;
        end
      end
      S_RREAD: begin
        if (tmr_done) begin
          seq_step = 1'b1;
          state_d  = rem_one ? S_DONE : S_RADDR;
        end
      end
      S_DONE:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      state_q        <= S_IDLE;
      op_q           <= OP_READ;
      data_q         <= '0;
      exp_q          <= '0;
      last_addr_q    <= '0;
      out_valid      <= 1'b0;
      out_addr       <= '0;
      out_data       <= '0;
      out_expect     <= '0;
      err_timeout    <= 1'b0;
      mismatch       <= 1'b0;
      first_bad_addr <= '0;
    end else begin
      state_q   <= state_d;
      out_valid <= (state_q == S_RREAD) && tmr_done;
      if (accept) begin
        op_q           <= op_e'(req_op);
        err_timeout    <= 1'b0;
        mismatch       <= 1'b0;
        first_bad_addr <= '0;
      end
      if (state_q == S_WLOAD && in_valid)
        data_q <= in_data;
      if (state_q == S_WSTROBE)
        last_addr_q <= seq_addr;
      if (state_q == S_RADDR && is_verify && in_valid)
        exp_q <= in_data;
      if (state_q == S_PREAD && tmr_done && poll_fail)
        err_timeout <= 1'b1;
      if (state_q == S_RREAD && tmr_done) begin
        out_addr   <= seq_addr;
        out_data   <= fl_dq_in;
        out_expect <= exp_q;
        if (is_verify && fl_dq_in != exp_q) begin
          mismatch <= 1'b1;
          if (!mismatch) first_bad_addr <= seq_addr;
        end
      end
    end
  end

  // pin decode
  assign req_ready = (state_q == S_IDLE);
  assign in_ready  = (state_q == S_WLOAD) || (state_q == S_RADDR && is_verify);
  assign done      = (state_q == S_DONE);
  assign fl_ce_n   = (state_q == S_IDLE) || (state_q == S_DONE);
  assign fl_we_n   = (state_q != S_WSTROBE);
  assign fl_oe_n   = !((state_q == S_PREAD) || (state_q == S_RREAD));
  assign fl_dq_oe  = (state_q == S_WSETTLE) || (state_q == S_WSTROBE);
  assign fl_dq_out = data_q;
  assign fl_addr   = (state_q == S_PGAP || state_q == S_PREAD) ? last_addr_q : seq_addr;

endmodule

// File: rtl/flash_page_prog_chk.sv
module flash_page_prog_chk #(
  parameter int ADDR_W = 15,
  parameter int PAGE_W = 6
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     req_valid,
  input logic                     req_ready,
  input logic                     fl_ce_n,
  input logic                     fl_oe_n,
  input logic                     fl_we_n,
  input logic                     fl_dq_oe,
  input logic [ADDR_W-PAGE_W-1:0] pg_addr,
  input logic                     mismatch,
  input logic [ADDR_W-1:0]        first_bad_addr
);

  logic                     pg_open_q;
  logic [ADDR_W-PAGE_W-1:0] pg_q;
  logic                     taken;

  assign taken = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_open_q <= 1'b0;
      pg_q      <= '0;
    end else if (!fl_we_n) begin
      pg_open_q <= 1'b1;
      pg_q      <= pg_addr;
    end else if (!fl_oe_n || req_ready) begin
      pg_open_q <= 1'b0;
    end
  end

  assert_we_oe_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(!fl_we_n && !fl_oe_n));

  assert_no_drive_in_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_oe_n |-> !fl_dq_oe);

  assert_drive_released_early_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fl_oe_n) |-> !$past(fl_dq_oe));

  assert_we_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_we_n |=> fl_we_n);

  assert_strobe_with_ce_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl_we_n || !fl_oe_n) |-> !fl_ce_n);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (fl_ce_n && fl_oe_n && fl_we_n && !fl_dq_oe));

  assert_page_grouped_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl_we_n && pg_open_q) |-> (pg_addr == pg_q));

  assert_mismatch_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mismatch && !taken) |=> mismatch);

  assert_first_bad_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mismatch && !taken) |=> $stable(first_bad_addr));

endmodule

bind flash_page_prog flash_page_prog_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_valid      (req_valid),
  .req_ready      (req_ready),
  .fl_ce_n        (fl_ce_n),
  .fl_oe_n        (fl_oe_n),
  .fl_we_n        (fl_we_n),
  .fl_dq_oe       (fl_dq_oe),
  .pg_addr        (fl_addr[ADDR_W-1:PAGE_W]),
  .mismatch       (mismatch),
  .first_bad_addr (first_bad_addr)
);

// File: tb/flash_page_prog_bench.sv
`timescale 1ns/1ps
module flash_page_prog_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = 2'b00;
  logic [14:0] req_addr = '0;
  logic [15:0] req_len = '0;
  logic [7:0]  settle_cyc;
  logic [15:0] poll_limit;
  logic        in_valid, in_ready;
  logic [7:0]  in_data;
  logic        out_valid;
  logic [14:0] out_addr, first_bad_addr, fl_addr;
  logic [7:0]  out_data, out_expect, fl_dq_out, fl_dq_in;
  logic        done, err_timeout, mismatch, fl_dq_oe, fl_ce_n, fl_oe_n, fl_we_n;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  int settle = 2;
  int limit = 100;
  int busy_len = 20;
  bit hang = 0;
  bit stall_mode = 0;

  assign settle_cyc = 8'(settle);
  assign poll_limit = 16'(limit);

  always #2 clk = ~clk;

  flash_page_prog u_flash_page_prog (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_len(req_len),
    .settle_cyc(settle_cyc), .poll_limit(poll_limit),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_addr(out_addr), .out_data(out_data),
    .out_expect(out_expect), .done(done), .err_timeout(err_timeout),
    .mismatch(mismatch), .first_bad_addr(first_bad_addr),
    .fl_addr(fl_addr), .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe),
    .fl_dq_in(fl_dq_in), .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n)
  );

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] patt(int a);
    return 8'(a * 7 + 3);
  endfunction

  // ---------------- device model ----------------
  logic [7:0]  mem [0:511];
  bit          written [0:511];
  int          busy = 0;
  logic [7:0]  last_b = 8'h00;
  int          oelow = 0;
  int          stab = 0;
  logic [14:0] pa = '0;
  logic [7:0]  pd = '0;
  int          groups = 0;
  bit          saw_oe = 1'b1;
  int          ce_cyc = 0;
  int          oe_falls = 0;
  logic        prev_oe_n = 1'b1;
  logic [7:0]  cur_v;

  assign cur_v = (busy > 0) ? ~last_b :
                 (written[fl_addr[8:0]] ? mem[fl_addr[8:0]] : patt(int'(fl_addr)));
  assign fl_dq_in = (!fl_oe_n && !fl_ce_n) ? ((oelow >= settle) ? cur_v : ~cur_v) : 8'h00;

  always @(posedge clk) begin
    if (!fl_we_n && !fl_ce_n) begin
      chk(stab >= settle, "R4", "stable cycles before write strobe", stab, settle);
      mem[fl_addr[8:0]]     <= fl_dq_out;
      written[fl_addr[8:0]] <= 1'b1;
      last_b <= fl_dq_out;
      busy   <= busy_len;
      if (saw_oe) groups <= groups + 1;
      saw_oe <= 1'b0;
    end else begin
      if (busy > 0 && !hang) busy <= busy - 1;
      if (!fl_oe_n) saw_oe <= 1'b1;
    end
    stab <= (fl_dq_oe && fl_addr == pa && fl_dq_out == pd) ? stab + 1 : (fl_dq_oe ? 1 : 0);
    pa <= fl_addr;
    pd <= fl_dq_out;
    oelow <= !fl_oe_n ? oelow + 1 : 0;
    if (!fl_oe_n && prev_oe_n) oe_falls <= oe_falls + 1;
    prev_oe_n <= fl_oe_n;
    if (!fl_ce_n) ce_cyc <= ce_cyc + 1;
  end

  // ---------------- stream driver ----------------
  logic [7:0] feed_q[$];
  bit rdy_q = 0;
  bit stall_tog = 0;

  initial begin
    in_valid = 1'b0;
    in_data  = 8'h00;
    forever begin
      @(negedge clk);
      if (in_valid && rdy_q) void'(feed_q.pop_front());
      stall_tog = ~stall_tog;
      in_valid = (feed_q.size() > 0) && !(stall_mode && stall_tog);
      in_data  = (feed_q.size() > 0) ? feed_q[0] : 8'h00;
      rdy_q    = in_ready;
    end
  end

  // ---------------- scoreboard ----------------
  logic [14:0] sb_addr[$];
  logic [7:0]  sb_data[$];
  logic [7:0]  sb_exp[$];
  bit          sb_vfy[$];
  string       sb_tag[$];
  logic [7:0]  img [0:511];

  initial begin
    forever begin
      @(negedge clk);
      if (out_valid) begin
        if (sb_addr.size() == 0) begin
          chk(1'b0, "R3", "unexpected result strobe", int'(out_addr), 0);
        end else begin
          automatic logic [14:0] ea = sb_addr.pop_front();
          automatic logic [7:0]  ed = sb_data.pop_front();
          automatic logic [7:0]  ee = sb_exp.pop_front();
          automatic bit          ev = sb_vfy.pop_front();
          automatic string       et = sb_tag.pop_front();
          chk(out_addr == ea, et, "result address", int'(out_addr), int'(ea));
          chk(out_data == ed, et, "result data", int'(out_data), int'(ed));
          if (ev) chk(out_expect == ee, "R10", "reference byte", int'(out_expect), int'(ee));
        end
      end
    end
  end

  // ---------------- request tasks ----------------
  task automatic issue(logic [1:0] op, int addr, int len);
    int guard;
    @(negedge clk);
    req_valid = 1'b1;
    req_op    = op;
    req_addr  = 15'(addr);
    req_len   = 16'(len);
    @(negedge clk);
    req_valid = 1'b0;
    guard = 0;
    while (!done && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    chk(done == 1'b1, "R2", "done pulse seen", int'(done), 1);
    @(negedge clk);
    chk(done == 1'b0, "R2", "done lasts one cycle", int'(done), 0);
    chk(sb_addr.size() == 0, "R3", "results outstanding", sb_addr.size(), 0);
  endtask

  task automatic do_read(int addr, int len, string tag);
    for (int i = 0; i < len; i++) begin
      sb_addr.push_back(15'(addr + i));
      sb_data.push_back(img[(addr + i) % 512]);
      sb_exp.push_back(8'h00);
      sb_vfy.push_back(1'b0);
      sb_tag.push_back(tag);
    end
    issue(2'b00, addr, len);
  endtask

  task automatic do_write(int addr, int len, int seed);
    for (int i = 0; i < len; i++) begin
      automatic logic [7:0] b = 8'(seed + i * 37);
      feed_q.push_back(b);
      img[(addr + i) % 512] = b;
    end
    issue(2'b01, addr, len);
  endtask

  task automatic do_verify(int addr, int len, int bad_a, int bad_b);
    for (int i = 0; i < len; i++) begin
      automatic logic [7:0] e = img[(addr + i) % 512];
      if (i == bad_a) e = e ^ 8'h01;
      if (i == bad_b) e = e ^ 8'h80;
      feed_q.push_back(e);
      sb_addr.push_back(15'(addr + i));
      sb_data.push_back(img[(addr + i) % 512]);
      sb_exp.push_back(e);
      sb_vfy.push_back(1'b1);
      sb_tag.push_back("R10");
    end
    issue(2'b10, addr, len);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(4 * 150000);
    if (!finished) begin
      finished = 1;
      bad++;
      total++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    int g0, f0, c0;
    for (int i = 0; i < 512; i++) img[i] = patt(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(req_ready == 1'b1, "R1", "req_ready after reset", int'(req_ready), 1);
    chk({fl_ce_n, fl_oe_n, fl_we_n} == 3'b111, "R1", "strobes idle", int'({fl_ce_n, fl_oe_n, fl_we_n}), 7);
    chk(fl_dq_oe == 1'b0, "R1", "bus drive idle", int'(fl_dq_oe), 0);
    chk({out_valid, done, err_timeout, mismatch} == 4'b0, "R1", "status idle",
        int'({out_valid, done, err_timeout, mismatch}), 0);
    chk(in_ready == 1'b0, "R12", "no byte wanted when idle", int'(in_ready), 0);

    // R3 R9 read with settling
    settle = 3;
    do_read(10, 8, "R9");

    // R4 R5 R6 write across a page boundary
    settle = 2;
    g0 = groups;
    f0 = oe_falls;
    do_write(58, 10, 5);
    chk(groups - g0 == 2, "R5", "polling phases for 6+4 bytes", groups - g0, 2);
    chk(busy == 0, "R6", "device busy at done", busy, 0);
    chk(oe_falls - f0 > 2, "R6", "repeated polling while busy", oe_falls - f0, 3);
    chk(err_timeout == 1'b0, "R6", "no timeout", int'(err_timeout), 0);
    do_read(56, 14, "R4");

    // R10 R12 verify clean with stalls
    stall_mode = 1;
    do_verify(58, 10, -1, -1);
    stall_mode = 0;
    chk(mismatch == 1'b0, "R10", "clean verify flag", int'(mismatch), 0);
    chk(feed_q.size() == 0, "R12", "stream bytes consumed", feed_q.size(), 0);

    // R10 verify with two bad bytes
    do_verify(10, 6, 2, 4);
    chk(mismatch == 1'b1, "R10", "mismatch flag", int'(mismatch), 1);
    chk(first_bad_addr == 15'd12, "R10", "first bad address", int'(first_bad_addr), 12);

    // R2 R11 empty operations
    c0 = ce_cyc;
    issue(2'b11, 20, 4);
    chk(mismatch == 1'b0, "R11", "mismatch cleared", int'(mismatch), 0);
    chk(first_bad_addr == 15'd0, "R11", "first bad cleared", int'(first_bad_addr), 0);
    issue(2'b00, 20, 0);
    chk(ce_cyc == c0, "R2", "no chip enable for empty requests", ce_cyc - c0, 0);

    // R7 timeout
    hang = 1;
    limit = 5;
    f0 = oe_falls;
    do_write(300, 2, 77);
    chk(err_timeout == 1'b1, "R7", "timeout flag", int'(err_timeout), 1);
    chk(oe_falls - f0 == 5, "R7", "poll read count", oe_falls - f0, 5);
    hang = 0;
    limit = 100;
    repeat (40) @(negedge clk);

    // R4 zero settling, R11 clears timeout
    settle = 0;
    do_write(200, 3, 200);
    chk(err_timeout == 1'b0, "R11", "timeout cleared", int'(err_timeout), 0);
    do_read(199, 5, "R4");

    // R5 one full aligned page
    settle = 1;
    g0 = groups;
    do_write(128, 64, 9);
    chk(groups - g0 == 1, "R5", "single polling phase for aligned page", groups - g0, 1);
    do_read(128, 64, "R5");
    do_read(300, 2, "R7");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule